// File: doc/BRIEF.md
# Framed parallel-port byte transmitter

This block sits on the peripheral side of a byte-wide parallel host port. Each processing cycle (a 25 us frame at about 40,000 frames per second) the internal logic hands it five 14-bit measurement values with a single-cycle frame-ready pulse. About 13 us of each frame remain for output after processing. In that time the block has to deliver all five values as a 10-byte burst that the host paces.

The block latches the five values and raises an interrupt request. The host then reads the burst. For each byte it pulls an active-low data strobe low for roughly 400 ns and releases it for roughly 400 ns. The strobe passes through a two-flop synchronizer. When the strobe is seen low, the block drives the next byte onto the bus and raises its wait/acknowledge line. When the strobe is seen high again, the block drops wait and moves to the following byte.

After the tenth byte the block goes idle until the next frame-ready pulse. A frame-ready pulse that arrives while a burst is still in progress is dropped, and it sets a sticky overrun flag.

Top module: `epp_frame_tx`

## Requirements
- R1: After reset, irq, wait_out, overrun and data_out are all zero.
- R2: A frame_ready pulse seen while idle latches all five samples and raises irq on the next clock.
- R3: When the synchronized strobe is seen low, the block loads the current byte onto data_out and raises wait_out in the same clock. irq is cleared when the first strobe of a burst is accepted.
- R4: When the synchronized strobe is seen high again, wait_out falls and the byte position advances by one.
- R5: Bytes go out in word order 0 to 4. Within each word the low byte (bits 7:0) goes first. The high byte follows and carries bits 13:8 in bits 5:0, with bits 7:6 forced to zero.
- R6: After the tenth byte the block returns to idle. In idle, strobes are ignored: wait_out stays low and irq stays low.
- R7: A frame_ready pulse while a burst is pending or in progress sets overrun. The new frame is dropped: no irq follows when the current burst ends.
- R8: A frame_ready pulse in the same clock in which the tenth byte completes counts as an overrun and is dropped. A pulse one clock later is accepted.
- R9: Changing the sample inputs after the frame has been latched has no effect on the bytes of that burst.
- R10: Once set, overrun stays high until reset and survives later good frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_ready | input | 1 | Single-cycle pulse: samples are valid |
| samples | input | 70 | Five 14-bit values, word 0 in bits 13:0 |
| strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| data_out | output | 8 | Byte presented to the host |
| irq | output | 1 | Interrupt request: a frame is waiting |
| wait_out | output | 1 | Handshake acknowledge to the host |
| overrun | output | 1 | Sticky flag: a frame was dropped |

## Verification
Burst completion and frame acceptance can fall in the same clock: the rise of the strobe for the tenth byte, and a new frame_ready pulse. The bench places the strobe rise on a falling clock edge and counts the two synchronizer stages. It then puts frame_ready exactly in the cycle where the block acts on that rise. It expects overrun to be set and no interrupt to follow. It then repeats the test one cycle later, where the frame must be accepted with irq and a correct burst.

// File: rtl/epp_tx_pkg.sv
package epp_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_HOLD = 2'd2,
    ST_NEXT = 2'd3
  } tx_state_t;
endpackage

// File: rtl/epp_strobe_sync.sv
module epp_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= strobe_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall = prev_q & ~sync_q;
  assign rise = ~prev_q & sync_q;
endmodule

// File: rtl/epp_frame_store.sv
module epp_frame_store #(
  parameter int NUM_WORDS = 5,
  parameter int WORD_W    = 14,
  parameter int BYTE_W    = 8,
  localparam int BPW      = (WORD_W + BYTE_W - 1) / BYTE_W,
  localparam int NUM_BYTES = NUM_WORDS * BPW,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_WORDS*WORD_W-1:0] samples,
  input  logic [IDX_W-1:0]            byte_idx,
  output logic [BYTE_W-1:0]           byte_val
);
  localparam int PAD_W = BPW * BYTE_W;

  logic [PAD_W-1:0] padded [NUM_WORDS];

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= samples[w*WORD_W +: WORD_W];
      end
      if (PAD_W > WORD_W) begin : g_pad
        assign padded[w] = {{(PAD_W-WORD_W){1'b0}}, word_q};
      end else begin : g_nopad
        assign padded[w] = word_q;
      end
    end
  endgenerate

  always_comb begin
    byte_val = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (byte_idx == IDX_W'(k))
        byte_val = padded[k / BPW][(k % BPW)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/epp_tx_fsm.sv
module epp_tx_fsm
  import epp_tx_pkg::*;
#(
  parameter int NUM_BYTES = 10,
  parameter int BYTE_W    = 8,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ready,
  input  logic              fall,
  input  logic              rise,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              load,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BYTE_W-1:0] data_out,
  output logic              irq,
  output logic              wait_out,
  output logic              overrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  tx_state_t         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              irq_q, irq_d;
  logic              wait_q, wait_d;
  logic              ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    data_d  = data_q;
    irq_d   = irq_q;
    wait_d  = wait_q;
    ovr_d   = ovr_q;
    load    = 1'b0;
    if (frame_ready && state_q != ST_IDLE) ovr_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (frame_ready) begin
          load    = 1'b1;
          idx_d   = '0;
          irq_d   = 1'b1;
          state_d = ST_PEND;
        end
      end
      ST_PEND, ST_NEXT: begin
        if (fall) begin
          data_d  = byte_val;
          wait_d  = 1'b1;
          irq_d   = 1'b0;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (rise) begin
          wait_d = 1'b0;
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_NEXT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
      wait_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      data_q  <= data_d;
      irq_q   <= irq_d;
      wait_q  <= wait_d;
      ovr_q   <= ovr_d;
    end
  end

  assign byte_idx = idx_q;
  assign data_out = data_q;
  assign irq      = irq_q;
  assign wait_out = wait_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/epp_frame_tx.sv
module epp_frame_tx #(
  parameter int NUM_WORDS = 5,
  parameter int WORD_W    = 14,
  parameter int BYTE_W    = 8,
  localparam int BPW       = (WORD_W + BYTE_W - 1) / BYTE_W,
  localparam int NUM_BYTES = NUM_WORDS * BPW,
  localparam int IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_ready,
  input  logic [NUM_WORDS*WORD_W-1:0] samples,
  input  logic                        strobe_n,
  output logic [BYTE_W-1:0]           data_out,
  output logic                        irq,
  output logic                        wait_out,
  output logic                        overrun
);
  logic              fall, rise, load;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] byte_val;

  epp_strobe_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .fall     (fall),
    .rise     (rise)
  );

  epp_frame_store #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .BYTE_W    (BYTE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .samples  (samples),
    .byte_idx (byte_idx),
    .byte_val (byte_val)
  );

  epp_tx_fsm #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_ready (frame_ready),
    .fall        (fall),
    .rise        (rise),
    .byte_val    (byte_val),
    .load        (load),
    .byte_idx    (byte_idx),
    .data_out    (data_out),
    .irq         (irq),
    .wait_out    (wait_out),
    .overrun     (overrun)
  );
endmodule

// File: rtl/epp_frame_tx_chk.sv
module epp_frame_tx_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_ready,
  input logic              strobe_n,
  input logic [BYTE_W-1:0] data_out,
  input logic              irq,
  input logic              wait_out,
  input logic              overrun
);
  // R3: wait only rises after the host strobe was low two clocks earlier
  p_wait_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_out) |-> !$past(strobe_n, 2));

  // R4: wait only falls after the host strobe was high two clocks earlier
  p_wait_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_out) |-> $past(strobe_n, 2));

  // R3: the presented byte holds while wait is high
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_out && $past(wait_out)) |-> $stable(data_out));

  // R2: irq only rises in response to a frame_ready pulse
  p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_ready));

  // R3: irq and wait never high together
  p_irq_wait_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && wait_out));

  // R10: overrun is sticky
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind epp_frame_tx epp_frame_tx_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_ready (frame_ready),
  .strobe_n    (strobe_n),
  .data_out    (data_out),
  .irq         (irq),
  .wait_out    (wait_out),
  .overrun     (overrun)
);

// File: tb/epp_frame_tx_test.sv
module epp_frame_tx_test;
  localparam int NW = 5;
  localparam int WW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_ready = 1'b0;
  logic [NW*WW-1:0] samples = '0;
  logic          strobe_n = 1'b1;
  logic [7:0]    data_out;
  logic          irq, wait_out, overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  epp_frame_tx uut (
    .clk (clk), .rst_n (rst_n), .frame_ready (frame_ready), .samples (samples),
    .strobe_n (strobe_n), .data_out (data_out), .irq (irq),
    .wait_out (wait_out), .overrun (overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: present a frame and push its expected bytes (R5 ordering)
  task automatic send_frame(input logic [WW-1:0] w0, w1, w2, w3, w4, input bit expect_accept);
    logic [WW-1:0] ws [NW];
    ws = '{w0, w1, w2, w3, w4};
    for (int i = 0; i < NW; i++) samples[i*WW +: WW] = ws[i];
    if (expect_accept)
      for (int i = 0; i < NW; i++) begin
        exp_q.push_back(ws[i][7:0]);
        exp_q.push_back({2'b00, ws[i][13:8]});
      end
    frame_ready = 1'b1;
    @(negedge clk);
    frame_ready = 1'b0;
  endtask

  // one host read cycle; monitor pops the expected byte
  task automatic read_byte(input bit coincide, input bit late);
    logic [7:0] e;
    strobe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 wait high", wait_out, 1);
    chk("R3 irq cleared", irq, 0);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk("R5 byte", data_out, e);
    repeat (74) @(negedge clk);
    strobe_n = 1'b1;
    if (coincide || late) begin
      @(posedge clk); @(posedge clk);
      if (late) @(posedge clk);
      @(negedge clk) frame_ready = 1'b1;
      @(negedge clk) frame_ready = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    chk("R4 wait low", wait_out, 0);
    repeat (74) @(negedge clk);
  endtask

  task automatic idle_strobe();
    strobe_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 wait ignores strobe in idle", wait_out, 0);
    chk("R6 irq low in idle", irq, 0);
    repeat (10) @(negedge clk);
    strobe_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 irq", irq, 0);
    chk("R1 wait", wait_out, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 data", data_out, 0);
    idle_strobe();

    // frame A: mid-burst sample change and overrun
    send_frame(14'h1234, 14'h0ABC, 14'h3FFF, 14'h0001, 14'h2A55, 1);
    chk("R2 irq raised", irq, 1);
    chk("R2 wait low while pending", wait_out, 0);
    for (int k = 0; k < 10; k++) begin
      read_byte(0, 0);
      if (k == 2) samples = '1;               // R9: must not alter this burst
      if (k == 4) begin
        send_frame(14'h0777, 14'h0777, 14'h0777, 14'h0777, 14'h0777, 0);
        chk("R7 overrun set", overrun, 1);
      end
    end
    repeat (4) @(negedge clk);
    chk("R7 dropped frame gives no irq", irq, 0);
    idle_strobe();
    chk("R10 overrun still set", overrun, 1);

    do_reset();
    chk("R10 overrun cleared by reset", overrun, 0);

    // frame B: frame_ready coincides with completion of the last byte
    send_frame(14'h0155, 14'h2AAA, 14'h1F00, 14'h00FF, 14'h3C3C, 1);
    chk("R2 irq raised", irq, 1);
    for (int k = 0; k < 10; k++) read_byte(k == 9, 0);
    chk("R8 coincident frame is overrun", overrun, 1);
    repeat (4) @(negedge clk);
    chk("R8 coincident frame dropped", irq, 0);

    do_reset();
    // frame C: last byte, frame_ready one clock after completion is accepted
    send_frame(14'h2001, 14'h0102, 14'h0304, 14'h0506, 14'h3807, 1);
    for (int k = 0; k < 9; k++) read_byte(0, 0);
    for (int i = 0; i < NW; i++) samples[i*WW +: WW] = 14'h1357;
    exp_q.push_back(8'h57); exp_q.push_back(8'h13);
    // the remaining queue entry belongs to frame C; the rest to frame D
    read_byte(0, 1);
    chk("R8 late frame not overrun", overrun, 0);
    chk("R8 late frame raises irq", irq, 1);
    for (int k = 0; k < 2; k++) read_byte(0, 0);
    // finish frame D reads to return to idle (remaining bytes also 57/13)
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(8'h57); exp_q.push_back(8'h13);
    end
    for (int k = 0; k < 8; k++) read_byte(0, 0);
    idle_strobe();
    send_frame(14'h0042, 14'h0, 14'h0, 14'h0, 14'h0, 1);
    chk("R2 irq after idle", irq, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule